// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Flags

This block is a single-clock, two-port RAM. Each port has its own enable, write strobe, address, write data and read data. Next to the data path sits a comparator that watches both ports in every cycle. When both ports are enabled on the same address in the same cycle, it raises a flag toward each port whose access that cycle may not have behaved as expected.

The rules for the flag depend on what each port is doing:

- A reader is flagged when the other port writes the same word.
- Both writers are flagged when both ports write the same word.
- Two readers are never flagged.

Each flag goes through the same number of register stages as the read data. A flag therefore lines up with the read word of the access that caused it: both appear after the second rising edge that follows the access. A system that issues burst accesses can use the flags to learn which transfers overlapped with the other port and may need to be repeated.

Storage works like an ordinary two-port RAM:

- A read returns the word as it stood before that cycle's writes (read-first).
- When both ports write the same word, the value from port A is kept.

Top module: `dpc_top`

## Requirements
- R1: A collision is a cycle in which both ports have enable high on the same address. Accesses to different addresses raise no flag on either port.
- R2: When either port has enable low in a cycle, that cycle raises no flag on either port, whatever its write strobe and address are.
- R3: When both ports read the same address (enable high, write strobe low), neither flag is raised.
- R4: When one port reads an address and the other port writes the same address, only the reading port's flag is raised.
- R5: When both ports write the same address, both flags are raised.
- R6: A flag caused by the access sampled at rising edge N goes high after edge N+1 and stays high for exactly one cycle, until edge N+2. It is low after edge N. Collisions on consecutive cycles give a flag that stays high for the same number of consecutive cycles.
- R7: The word read by an access sampled at edge N appears on that port's read data after edge N+1. It holds the contents from before any write in that same cycle. While the port's enable stays low, the read data keeps its last value.
- R8: When both ports write the same address in one cycle, port A's write data is the value that is stored.
- R9: An active-low reset (rst_n = 0) clears both flags and both read-data outputs to zero at once, without waiting for a clock edge.
- R10: A word written through one port with enable high can be read back through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ce | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, two edges after the access |
| a_coll | output | 1 | Port A collision flag, two edges after the access |
| b_ce | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, two edges after the access |
| b_coll | output | 1 | Port B collision flag, two edges after the access |

## Verification
A table drives every pairing of read and write on a shared address: read/read, read/write in both directions, and write/write, including the top address and address zero. The same table also covers near-misses: different addresses, and one port disabled while its strobe and address match the other port. The shared-address cases show that each rule flags the right port. The near-miss cases show that address equality and both enables are all needed.

Directed sequences use back-to-back collisions to pin down the two-edge latency and the one-cycle pulse width. A read that collides with a write shows that the flag and the old word arrive together. A double write followed by readback confirms that port A's value is kept. A reset applied while a flag is still in the pipeline confirms that the reset clears it at once.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e classify(input logic ce, input logic we);
    if (!ce)
      return ACC_IDLE;
    else if (we)
      return ACC_WRITE;
    else
      return ACC_READ;
  endfunction

  // Returns {flag_for_a, flag_for_b} for one cycle.
  // A port is flagged only when the opposite port is writing the same word.
  function automatic logic [1:0] flag_rule(input acc_e acc_a, input acc_e acc_b,
                                           input logic same_word);
    logic fa;
    logic fb;
    fa = 1'b0;
    fb = 1'b0;
    if (same_word && acc_a != ACC_IDLE && acc_b != ACC_IDLE) begin
      fa = (acc_b == ACC_WRITE);
      fb = (acc_a == ACC_WRITE);
    end
    return {fa, fb};
  endfunction

endpackage

// File: rtl/dpc_collide.sv
module dpc_collide
  import dpc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          a_ce,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic          b_ce,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  output logic          hit,
  output logic          a_raise,
  output logic          b_raise
);

  acc_e       acc_a;
  acc_e       acc_b;
  logic       same_word;
  logic [1:0] raise;

  always_comb begin
    acc_a     = classify(a_ce, a_we);
    acc_b     = classify(b_ce, b_we);
    same_word = (a_addr == b_addr);
    hit       = same_word && (acc_a != ACC_IDLE) && (acc_b != ACC_IDLE);
    raise     = flag_rule(acc_a, acc_b, same_word);
    a_raise   = raise[1];
    b_raise   = raise[0];
  end

endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_ce,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] a_rd_q,
  output logic [DW-1:0] b_rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic          a_wr;
  logic          b_wr;

  assign a_wr = a_ce && a_we;
  // Port B loses a same-word double write to port A.
  assign b_wr = b_ce && b_we && !(a_wr && a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (b_wr)
      store[b_addr] <= b_wdata;
    if (a_wr)
      store[a_addr] <= a_wdata;
  end

  // Read-first first stage: captures contents from before this edge's writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rd_q <= '0;
      b_rd_q <= '0;
    end else begin
      if (a_ce)
        a_rd_q <= store[a_addr];
      if (b_ce)
        b_rd_q <= store[b_addr];
    end
  end

endmodule

// File: rtl/dpc_pipe.sv
module dpc_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            stage_q[s] <= '0;
          else if (s == 0)
            stage_q[s] <= din;
          else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dpc_top.sv
module dpc_top #(
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_coll,
  input  logic          b_ce,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_coll
);

  // The memory holds the first read stage; the rest is a plain delay line.
  localparam int DATA_STAGES = (LAT > 1) ? LAT - 1 : 0;
  localparam int FLAG_STAGES = (LAT > 1) ? LAT : 1;

  logic          hit;
  logic          a_raise;
  logic          b_raise;
  logic [DW-1:0] a_rd_q;
  logic [DW-1:0] b_rd_q;
  logic [1:0]    flag_out;

  dpc_collide #(.AW(AW)) u_collide (
    .a_ce    (a_ce),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .b_ce    (b_ce),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .hit     (hit),
    .a_raise (a_raise),
    .b_raise (b_raise)
  );

  dpc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_ce    (a_ce),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .b_ce    (b_ce),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .a_rd_q  (a_rd_q),
    .b_rd_q  (b_rd_q)
  );

  dpc_pipe #(.W(DW), .STAGES(DATA_STAGES)) u_a_data (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (a_rd_q),
    .dout  (a_rdata)
  );

  dpc_pipe #(.W(DW), .STAGES(DATA_STAGES)) u_b_data (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (b_rd_q),
    .dout  (b_rdata)
  );

  dpc_pipe #(.W(2), .STAGES(FLAG_STAGES)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({a_raise, b_raise}),
    .dout  (flag_out)
  );

  assign a_coll = flag_out[1];
  assign b_coll = flag_out[0];

endmodule

// File: rtl/dpc_top_chk.sv
module dpc_top_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_ce,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic          b_ce,
  input logic          b_we,
  input logic [AW-1:0] b_addr,
  input logic          hit,
  input logic          a_coll,
  input logic          b_coll
);

  // R1
  diff_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && b_ce && a_addr != b_addr) |-> ##2 (!a_coll && !b_coll));

  // R2
  idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ce || !b_ce) |-> ##2 (!a_coll && !b_coll));

  // R3
  dual_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && b_ce && !a_we && !b_we && a_addr == b_addr) |-> ##2 (!a_coll && !b_coll));

  // R4
  reader_a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && b_ce && !a_we && b_we && a_addr == b_addr) |-> ##2 (a_coll && !b_coll));

  // R4
  reader_b_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && b_ce && a_we && !b_we && a_addr == b_addr) |-> ##2 (!a_coll && b_coll));

  // R5
  dual_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && b_ce && a_we && b_we && a_addr == b_addr) |-> ##2 (a_coll && b_coll));

  // R6
  flag_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_coll || b_coll) |-> $past(hit, 2));

endmodule

bind dpc_top dpc_top_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_ce   (a_ce),
  .a_we   (a_we),
  .a_addr (a_addr),
  .b_ce   (b_ce),
  .b_we   (b_we),
  .b_addr (b_addr),
  .hit    (hit),
  .a_coll (a_coll),
  .b_coll (b_coll)
);

// File: tb/dpc_top_bench.sv
module dpc_top_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_ce = 1'b0, a_we = 1'b0, b_ce = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          a_coll, b_coll;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpc_top #(.AW(AW), .DW(DW), .LAT(2)) u_dpc_top (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_coll(a_coll),
    .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_coll(b_coll)
  );

  // {a_ce, a_we, a_addr, b_ce, b_we, b_addr, exp_a_coll, exp_b_coll}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd3,  1'b1, 1'b0, 6'd3,  1'b0, 1'b0},
    {1'b1, 1'b0, 6'd3,  1'b1, 1'b1, 6'd3,  1'b1, 1'b0},
    {1'b1, 1'b1, 6'd4,  1'b1, 1'b0, 6'd4,  1'b0, 1'b1},
    {1'b1, 1'b1, 6'd5,  1'b1, 1'b1, 6'd5,  1'b1, 1'b1},
    {1'b1, 1'b0, 6'd6,  1'b1, 1'b0, 6'd7,  1'b0, 1'b0},
    {1'b1, 1'b1, 6'd6,  1'b1, 1'b1, 6'd7,  1'b0, 1'b0},
    {1'b0, 1'b1, 6'd8,  1'b1, 1'b1, 6'd8,  1'b0, 1'b0},
    {1'b1, 1'b0, 6'd8,  1'b0, 1'b1, 6'd8,  1'b0, 1'b0},
    {1'b1, 1'b0, 6'd63, 1'b1, 1'b1, 6'd63, 1'b1, 1'b0},
    {1'b1, 1'b1, 6'd0,  1'b1, 1'b1, 6'd0,  1'b1, 1'b1},
    {1'b1, 1'b0, 6'd10, 1'b1, 1'b1, 6'd11, 1'b0, 1'b0},
    {1'b1, 1'b1, 6'd12, 1'b1, 1'b0, 6'd12, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ace, input logic awe, input logic [AW-1:0] aad,
                       input logic [DW-1:0] awd, input logic bce, input logic bwe,
                       input logic [AW-1:0] bad_addr, input logic [DW-1:0] bwd);
    a_ce = ace; a_we = awe; a_addr = aad; a_wdata = awd;
    b_ce = bce; b_we = bwe; b_addr = bad_addr; b_wdata = bwd;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string rule_tag(input logic [17:0] v);
    if (!v[17] || !v[9]) return "R2";
    if (v[15:10] != v[7:2]) return "R1";
    if (!v[16] && !v[8]) return "R3";
    if (v[16] && v[8]) return "R5";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 a_coll after reset", a_coll, 0);
    check("R9 b_coll after reset", b_coll, 0);
    check("R9 a_rdata after reset", a_rdata, 0);
    check("R9 b_rdata after reset", b_rdata, 0);
    rst_n = 1'b1;
    tick();

    // Table walk: R1, R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17], VEC[i][16], VEC[i][15:10], DW'(i + 16'h100),
            VEC[i][9], VEC[i][8], VEC[i][7:2], DW'(i + 16'h200));
      tick();
      idle();
      tick();
      check($sformatf("%s vec %0d a_coll", rule_tag(VEC[i]), i), a_coll, VEC[i][1]);
      check($sformatf("%s vec %0d b_coll", rule_tag(VEC[i]), i), b_coll, VEC[i][0]);
    end

    // R10: write via A, read via B
    drive(1'b1, 1'b1, 6'd20, 16'h1234, 1'b0, 1'b0, '0, '0);
    tick();
    drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 6'd20, '0);
    tick();
    idle();
    tick();
    check("R10 b_rdata of A write", b_rdata, 16'h1234);

    // R8: double write keeps port A value
    drive(1'b1, 1'b1, 6'd21, 16'hAAAA, 1'b1, 1'b1, 6'd21, 16'hBBBB);
    tick();
    drive(1'b1, 1'b0, 6'd21, '0, 1'b1, 1'b0, 6'd21, '0);
    tick();
    idle();
    tick();
    check("R8 a_rdata after double write", a_rdata, 16'hAAAA);
    check("R8 b_rdata after double write", b_rdata, 16'hAAAA);

    // R7: read-first with a colliding write, flag aligned with data
    drive(1'b1, 1'b1, 6'd22, 16'h1111, 1'b0, 1'b0, '0, '0);
    tick();
    drive(1'b1, 1'b0, 6'd22, '0, 1'b1, 1'b1, 6'd22, 16'h2222);
    tick();
    idle();
    tick();
    check("R7 a_rdata old word on collision", a_rdata, 16'h1111);
    check("R4 a_coll with aligned data", a_coll, 1);
    drive(1'b1, 1'b0, 6'd22, '0, 1'b0, 1'b0, '0, '0);
    tick();
    idle();
    check("R7 a_rdata not yet updated after one edge", a_rdata, 16'h1111);
    tick();
    check("R7 a_rdata new word after two edges", a_rdata, 16'h2222);
    tick();
    tick();
    check("R7 a_rdata held while idle", a_rdata, 16'h2222);

    // R6: three back-to-back collisions
    drive(1'b1, 1'b1, 6'd30, 16'h0001, 1'b1, 1'b1, 6'd30, 16'h0002);
    tick();
    check("R6 a_coll low after first edge", a_coll, 0);
    tick();
    check("R6 a_coll high after second edge", a_coll, 1);
    tick();
    check("R6 b_coll high second cycle", b_coll, 1);
    idle();
    tick();
    check("R6 a_coll high third cycle", a_coll, 1);
    tick();
    check("R6 a_coll low after run", a_coll, 0);
    check("R6 b_coll low after run", b_coll, 0);

    // R9: reset with a flag in flight
    drive(1'b1, 1'b1, 6'd31, 16'h5555, 1'b1, 1'b1, 6'd31, 16'h6666);
    tick();
    idle();
    rst_n = 1'b0;
    #1;
    check("R9 a_coll cleared at reset", a_coll, 0);
    check("R9 b_coll cleared at reset", b_coll, 0);
    check("R9 a_rdata cleared at reset", a_rdata, 0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R9 b_coll stays low after reset", b_coll, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule